// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel bytes into asynchronous NRZ serial frames. Each frame is a low start bit, then eight or nine data bits with the least significant bit first, then a high stop bit. No parity is generated. The host writes a byte into a one-entry holding register. An internal shift register takes bytes from that holding register, so the host can queue the next byte while the current frame is still on the line. Frames can then follow each other with no idle gap.

A reload counter sets the bit rate. It has an 8-bit reload value and emits a tick every `divReload + 1` clocks. A mode input selects whether one bit lasts 16 or 64 of those ticks. Two flags are visible to the host: one says the holding register is free, the other says the shifter has no frame in flight. When the enable input is low, the transmitter resets its shifting state and releases the serial line, which is then flagged as not driven. Bytes written while the block is disabled stay in the holding register. They are sent once the block is enabled.

Top module: `dbuf_serial_tx`

## Requirements
- R1: After reset, and one cycle after `enable` goes low, `txDriveEn` is 0 and `txOut` is 1. After reset both `bufEmpty` and `shiftEmpty` are 1.
- R2: A frame is one low start bit, then the data bits least significant bit first, then one high stop bit. There are 8 data bits when `wordWide9` = 0 and 9 when it is 1, where bit 8 is the ninth bit.
- R3: Every bit of a frame, start and stop included, lasts exactly (divReload+1)×16 clocks when `fastMode` = 1 and (divReload+1)×64 clocks when `fastMode` = 0.
- R4: A frame's start bit begins only on a bit boundary. Bit boundaries fall at whole multiples of one bit period after the clock edge that first samples `enable` high. A byte written while disabled is held (`bufEmpty` = 0) and starts exactly one bit period after that edge.
- R5: A write while enabled with the shifter idle moves the byte straight into the shifter. In the following cycle `bufEmpty` = 1 and `shiftEmpty` = 0.
- R6: A write while a frame is in flight, or while the block is disabled, leaves `bufEmpty` = 0 until the transfer. The transfer takes place at the end of the current stop bit, and the next start bit follows with no idle gap.
- R7: A write to a full holding register replaces its contents. The frame being shifted is unchanged, and only the last byte written is sent.
- R8: `shiftEmpty` is 1 exactly when no frame is loaded or in flight. It rises at the end of a stop bit when nothing is queued, and the line is high while it is 1.
- R9: In 9-bit mode the ninth bit is the value of `bit9In` at the cycle the byte enters the shifter. For a byte that waits in the holding register, a later change of `bit9In` is what gets sent.
- R10: Lowering `enable` during a frame aborts it. In the next cycle `shiftEmpty` = 1 and the line is released. On re-enable no remnant of the aborted frame is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Transmitter enable; low aborts and releases the line |
| fastMode | input | 1 | 1: 16 ticks per bit, 0: 64 ticks per bit |
| divReload | input | 8 | Reload value of the baud tick counter (tick every value+1 clocks) |
| wordWide9 | input | 1 | 1 selects nine data bits per frame |
| bit9In | input | 1 | Ninth data bit, sampled when a byte enters the shifter |
| dataIn | input | 8 | Byte to transmit |
| dataWrite | input | 1 | One-cycle write strobe for `dataIn` |
| bufEmpty | output | 1 | Holding register free |
| shiftEmpty | output | 1 | Shifter idle, no frame loaded or in flight |
| txOut | output | 1 | Serial data line |
| txDriveEn | output | 1 | Output drive enable for the serial line (0 = high impedance) |

## Verification
The bound checker tests some relations on every cycle. It checks that the drive enable and the shifter state follow `enable` within one cycle, that an idle shifter always leaves the line high, that a write while enabled always puts a frame in flight, and that a write while busy or disabled leaves the buffer full. It also checks that a byte never lingers in the buffer while the shifter sits idle. Other behaviour depends on whole frames and on bit timing, so only the bench's scenarios can show it. This covers the exact length of each bit, the alignment of start bits to the bit grid after enable, the zero gap between back-to-back frames, the overwrite of a queued byte, the ninth bit taken at transfer time, and a silent line after an abort.

// File: rtl/dbtx_pkg.sv
package dbtx_pkg;

  // Strobes from the control FSM to the datapath, one cycle each.
  typedef struct packed {
    logic captureIn;  // write dataIn into the holding register
    logic xferHold;   // move holding register into the shifter
    logic xferIn;     // move dataIn straight into the shifter
    logic lineStart;  // drive the start bit
    logic lineShift;  // drive next data bit from the shifter
    logic lineStop;   // drive the stop bit
    logic lineIdle;   // return the line to its idle level
  } txStrobe_t;

endpackage

// File: rtl/dbtx_ctrl.sv
module dbtx_ctrl
  import dbtx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_W    = 8,
  parameter int OVS_FAST = 16,
  parameter int OVS_SLOW = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             fastMode,
  input  logic [DIV_W-1:0] divReload,
  input  logic             dataWrite,
  input  logic             holdFull,
  input  logic             frameNine,
  output txStrobe_t        strb,
  output logic             shiftIdle
);

  localparam int PHASE_W = $clog2(OVS_SLOW);
  localparam int IDX_W   = $clog2(DATA_W + 3);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SEND  = 2'd2
  } txState_e;

  txState_e           state;
  logic [DIV_W-1:0]   divCnt;
  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] lastPhase;
  logic [IDX_W-1:0]   bitIdx;
  logic [IDX_W-1:0]   dataBits;
  logic               baudTick;
  logic               boundary;
  logic               avail;
  logic               takeNow;

  // Baud tick: one pulse every divReload+1 enabled clocks.
  assign baudTick = enable && (divCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      divCnt <= divReload;
    end else if (divCnt == '0) begin
      divCnt <= divReload;
    end else begin
      divCnt <= divCnt - DIV_W'(1);
    end
  end

  // Oversample phase within one bit period.
  assign lastPhase = fastMode ? PHASE_W'(OVS_FAST - 1) : PHASE_W'(OVS_SLOW - 1);
  assign boundary  = baudTick && (phase >= lastPhase);

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      phase <= '0;
    end else if (baudTick) begin
      phase <= (phase >= lastPhase) ? '0 : phase + PHASE_W'(1);
    end
  end

  assign dataBits = frameNine ? IDX_W'(DATA_W + 1) : IDX_W'(DATA_W);
  assign avail    = holdFull || dataWrite;

  always_comb begin
    strb    = '0;
    takeNow = 1'b0;
    if (!enable) begin
      strb.lineIdle = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE:  takeNow = avail;
        ST_ARMED: strb.lineStart = boundary;
        ST_SEND: begin
          if (boundary) begin
            if (bitIdx < dataBits) begin
              strb.lineShift = 1'b1;
            end else if (bitIdx == dataBits) begin
              strb.lineStop = 1'b1;
            end else if (avail) begin
              takeNow        = 1'b1;
              strb.lineStart = 1'b1;
            end else begin
              strb.lineIdle = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
    if (takeNow) begin
      if (holdFull) begin
        strb.xferHold  = 1'b1;
        strb.captureIn = dataWrite;
      end else begin
        strb.xferIn = 1'b1;
      end
    end else begin
      strb.captureIn = dataWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      state  <= ST_IDLE;
      bitIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (avail) state <= ST_ARMED;
        end
        ST_ARMED: begin
          if (boundary) begin
            state  <= ST_SEND;
            bitIdx <= '0;
          end
        end
        ST_SEND: begin
          if (boundary) begin
            if (bitIdx <= dataBits) begin
              bitIdx <= bitIdx + IDX_W'(1);
            end else if (avail) begin
              bitIdx <= '0;
            end else begin
              state  <= ST_IDLE;
              bitIdx <= '0;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign shiftIdle = (state == ST_IDLE);

endmodule

// File: rtl/dbtx_datapath.sv
module dbtx_datapath
  import dbtx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              wordWide9,
  input  logic              bit9In,
  input  logic [DATA_W-1:0] dataIn,
  input  txStrobe_t         strb,
  output logic              holdFull,
  output logic              frameNine,
  output logic              lineOut,
  output logic              driveOut
);

  localparam int SH_W = DATA_W + 1;

  logic [DATA_W-1:0] holdData;
  logic [SH_W-1:0]   shiftData;

  // Holding register: capture wins over a simultaneous drain.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdData <= '0;
      holdFull <= 1'b0;
    end else begin
      if (strb.captureIn) begin
        holdData <= dataIn;
        holdFull <= 1'b1;
      end else if (strb.xferHold) begin
        holdFull <= 1'b0;
      end
    end
  end

  // Shift register; ninth bit and width are taken at transfer time.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftData <= '0;
      frameNine <= 1'b0;
    end else if (strb.xferHold) begin
      shiftData <= {bit9In, holdData};
      frameNine <= wordWide9;
    end else if (strb.xferIn) begin
      shiftData <= {bit9In, dataIn};
      frameNine <= wordWide9;
    end else if (strb.lineShift) begin
      shiftData <= {1'b0, shiftData[SH_W-1:1]};
    end
  end

  // Serial line register.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineOut <= 1'b1;
    end else if (strb.lineStart) begin
      lineOut <= 1'b0;
    end else if (strb.lineShift) begin
      lineOut <= shiftData[0];
    end else if (strb.lineStop || strb.lineIdle) begin
      lineOut <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      driveOut <= 1'b0;
    end else begin
      driveOut <= enable;
    end
  end

endmodule

// File: rtl/dbuf_serial_tx.sv
module dbuf_serial_tx
  import dbtx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_W    = 8,
  parameter int OVS_FAST = 16,
  parameter int OVS_SLOW = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              fastMode,
  input  logic [DIV_W-1:0]  divReload,
  input  logic              wordWide9,
  input  logic              bit9In,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              dataWrite,
  output logic              bufEmpty,
  output logic              shiftEmpty,
  output logic              txOut,
  output logic              txDriveEn
);

  txStrobe_t strb;
  logic      holdFull;
  logic      frameNine;
  logic      shiftIdle;

  dbtx_ctrl #(
    .DATA_W  (DATA_W),
    .DIV_W   (DIV_W),
    .OVS_FAST(OVS_FAST),
    .OVS_SLOW(OVS_SLOW)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .fastMode (fastMode),
    .divReload(divReload),
    .dataWrite(dataWrite),
    .holdFull (holdFull),
    .frameNine(frameNine),
    .strb     (strb),
    .shiftIdle(shiftIdle)
  );

  dbtx_datapath #(
    .DATA_W(DATA_W)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .wordWide9(wordWide9),
    .bit9In   (bit9In),
    .dataIn   (dataIn),
    .strb     (strb),
    .holdFull (holdFull),
    .frameNine(frameNine),
    .lineOut  (txOut),
    .driveOut (txDriveEn)
  );

  assign bufEmpty   = !holdFull;
  assign shiftEmpty = shiftIdle;

endmodule

// File: rtl/dbtx_checker.sv
module dbtx_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic dataWrite,
  input logic bufEmpty,
  input logic shiftEmpty,
  input logic txOut,
  input logic txDriveEn
);

  // R1: the line is released one cycle after enable drops
  a_r1_drive_follows_enable: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !txDriveEn);

  // R1: a released line reads as idle high
  a_r1_released_line_high: assert property (@(posedge clk) disable iff (!rstN)
    !txDriveEn |-> txOut);

  // R8: an idle shifter leaves the line high
  a_r8_idle_line_high: assert property (@(posedge clk) disable iff (!rstN)
    shiftEmpty |-> txOut);

  // R10: disabling resets the shifter
  a_r10_abort_clears: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> shiftEmpty);

  // R5: an enabled write always puts a frame in flight
  a_r5_write_loads: assert property (@(posedge clk) disable iff (!rstN)
    (enable && dataWrite) |=> !shiftEmpty);

  // R6: a write while busy or disabled leaves the buffer full
  a_r6_buffer_fills: assert property (@(posedge clk) disable iff (!rstN)
    (dataWrite && (!enable || !bufEmpty)) |=> !bufEmpty);

  // R5: a full buffer never waits on an idle, enabled shifter
  a_r5_no_lingering: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && !bufEmpty) |-> !shiftEmpty);

endmodule

bind dbuf_serial_tx dbtx_checker uChk (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .dataWrite (dataWrite),
  .bufEmpty  (bufEmpty),
  .shiftEmpty(shiftEmpty),
  .txOut     (txOut),
  .txDriveEn (txDriveEn)
);

// File: tb/tb_dbuf_serial_tx.sv
`timescale 1ns/1ps
module tb_dbuf_serial_tx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       fastMode = 1'b1;
  logic [7:0] divReload = 8'd0;
  logic       wordWide9 = 1'b0;
  logic       bit9In = 1'b0;
  logic [7:0] dataIn = 8'd0;
  logic       dataWrite = 1'b0;
  logic       bufEmpty, shiftEmpty, txOut, txDriveEn;

  int cyc = 0;
  int nChecks = 0;
  int nFail = 0;
  int bitP = 16;
  int enCyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dbuf_serial_tx dut (
    .clk(clk), .rstN(rstN), .enable(enable), .fastMode(fastMode),
    .divReload(divReload), .wordWide9(wordWide9), .bit9In(bit9In),
    .dataIn(dataIn), .dataWrite(dataWrite), .bufEmpty(bufEmpty),
    .shiftEmpty(shiftEmpty), .txOut(txOut), .txDriveEn(txDriveEn)
  );

  function automatic int periodOf(input int dv, input logic fst);
    return (dv + 1) * (fst ? 16 : 64);
  endfunction

  function automatic logic [8:0] expFrame(input logic nine, input logic b9, input logic [7:0] d);
    return {nine ? b9 : 1'b0, d};
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  task automatic setCfg(input int dv, input logic fst, input logic nine);
    divReload = 8'(dv);
    fastMode  = fst;
    wordWide9 = nine;
    bitP      = periodOf(dv, fst);
  endtask

  // Called at a negedge; returns at the negedge after the write edge.
  task automatic writeByte(input logic [7:0] d, input logic b9);
    dataIn = d; bit9In = b9; dataWrite = 1'b1;
    @(negedge clk);
    dataWrite = 1'b0;
  endtask

  // Called at a negedge; returns at the negedge after the stop bit.
  task automatic recvFrame(input int nb, output logic [8:0] val, output int st,
                           output int lenErr, output logic fmtOk);
    logic a, b;
    val = '0; lenErr = 0; fmtOk = 1'b1;
    while (!(txDriveEn === 1'b1 && txOut === 1'b0)) @(negedge clk);
    st = cyc;
    for (int k = 0; k < nb + 2; k++) begin
      a = txOut;
      repeat (bitP - 1) @(negedge clk);
      b = txOut;
      if (a !== b) lenErr++;
      if (k == 0 && a !== 1'b0) fmtOk = 1'b0;
      else if (k == nb + 1 && a !== 1'b1) fmtOk = 1'b0;
      else if (k > 0 && k <= nb) val[k-1] = a;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
    summary();
    $finish;
  end

  initial begin
    logic [8:0] v1, v2;
    int s1, s2, le1, le2, bad;
    logic ok1, ok2;
    void'($urandom(32'd20240611));

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 / R8: reset state
    check(bufEmpty === 1'b1 && shiftEmpty === 1'b1, "R1 flags after reset",
          {bufEmpty, shiftEmpty}, 2'b11);
    check(txDriveEn === 1'b0 && txOut === 1'b1, "R1 line after reset",
          {txDriveEn, txOut}, 2'b01);

    // R4: byte written while disabled starts one bit period after enable
    setCfg(1, 1'b1, 1'b0);
    writeByte(8'hA5, 1'b0);
    check(bufEmpty === 1'b0 && shiftEmpty === 1'b1, "R4 held while disabled",
          {bufEmpty, shiftEmpty}, 2'b01);
    enable = 1'b1; enCyc = cyc;
    @(negedge clk);
    check(bufEmpty === 1'b1 && shiftEmpty === 1'b0, "R5 transfer on enable",
          {bufEmpty, shiftEmpty}, 2'b10);
    recvFrame(8, v1, s1, le1, ok1);
    check(s1 - enCyc == bitP, "R4 start one period after enable", s1 - enCyc, bitP);
    check(ok1 && v1[7:0] == 8'hA5, "R2 frame A5", v1, 9'h0A5);
    check(le1 == 0, "R3 bit lengths 16x", le1, 0);
    check(shiftEmpty === 1'b1 && txOut === 1'b1, "R8 idle after stop",
          {shiftEmpty, txOut}, 2'b11);

    // R5: immediate transfer while idle, start on the bit grid
    repeat (7) @(negedge clk);
    writeByte(8'h5A, 1'b0);
    check(bufEmpty === 1'b1 && shiftEmpty === 1'b0, "R5 direct load",
          {bufEmpty, shiftEmpty}, 2'b10);
    recvFrame(8, v1, s1, le1, ok1);
    check((s1 - enCyc) % bitP == 0, "R4 start on boundary", (s1 - enCyc) % bitP, 0);
    check(ok1 && v1[7:0] == 8'h5A, "R2 frame 5A", v1, 9'h05A);

    // R6 / R7 / R9: back-to-back 9-bit frames, overwrite, late ninth bit
    enable = 1'b0;
    @(negedge clk);
    setCfg(0, 1'b0, 1'b1);
    enable = 1'b1; enCyc = cyc;
    @(negedge clk);
    writeByte(8'h3C, 1'b1);
    writeByte(8'h11, 1'b1);
    check(bufEmpty === 1'b0, "R6 buffer full while busy", bufEmpty, 0);
    writeByte(8'h22, 1'b1);
    bit9In = 1'b0;
    check(bufEmpty === 1'b0, "R7 still full after overwrite", bufEmpty, 0);
    recvFrame(9, v1, s1, le1, ok1);
    recvFrame(9, v2, s2, le2, ok2);
    check(ok1 && v1 == expFrame(1'b1, 1'b1, 8'h3C), "R9 first frame ninth bit",
          v1, expFrame(1'b1, 1'b1, 8'h3C));
    check(ok2 && v2 == expFrame(1'b1, 1'b0, 8'h22), "R7 R9 overwritten frame",
          v2, expFrame(1'b1, 1'b0, 8'h22));
    check(s2 - s1 == 11 * bitP, "R6 no gap", s2 - s1, 11 * bitP);
    check(le1 == 0 && le2 == 0, "R3 bit lengths 64x", le1 + le2, 0);
    check(shiftEmpty === 1'b1 && bufEmpty === 1'b1, "R8 both empty at end",
          {shiftEmpty, bufEmpty}, 2'b11);

    // R10: abort mid-frame
    @(negedge clk);
    writeByte(8'h55, 1'b0);
    while (txOut !== 1'b0) @(negedge clk);
    repeat (3 * bitP + 5) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(txDriveEn === 1'b0 && shiftEmpty === 1'b1, "R10 abort releases",
          {txDriveEn, shiftEmpty}, 2'b01);
    check(txOut === 1'b1, "R1 line high when released", txOut, 1);
    enable = 1'b1;
    bad = 0;
    repeat (3 * bitP) begin
      @(negedge clk);
      if (txOut !== 1'b1 || shiftEmpty !== 1'b1) bad++;
    end
    check(bad == 0, "R10 no remnant after re-enable", bad, 0);

    // Random trials: R2 R3 R6
    for (int t = 0; t < 6; t++) begin
      logic [7:0] dat [4];
      logic nine, b9, fst;
      int dv;
      enable = 1'b0;
      @(negedge clk);
      dv = int'($urandom_range(0, 2));
      fst = 1'($urandom_range(0, 1));
      nine = 1'($urandom_range(0, 1));
      b9 = 1'($urandom_range(0, 1));
      setCfg(dv, fst, nine);
      bit9In = b9;
      for (int i = 0; i < 4; i++) dat[i] = 8'($urandom);
      enable = 1'b1;
      repeat (int'($urandom_range(1, 20))) @(negedge clk);
      fork
        begin
          for (int i = 0; i < 4; i++) begin
            while (bufEmpty !== 1'b1) @(negedge clk);
            writeByte(dat[i], b9);
          end
        end
        begin
          int prevSt;
          prevSt = 0;
          for (int i = 0; i < 4; i++) begin
            logic [8:0] v;
            int st, le;
            logic ok;
            recvFrame(nine ? 9 : 8, v, st, le, ok);
            check(ok && v == expFrame(nine, b9, dat[i]), "R2 random frame",
                  v, expFrame(nine, b9, dat[i]));
            check(le == 0, "R3 random bit lengths", le, 0);
            if (i > 0)
              check(st - prevSt == (nine ? 11 : 10) * bitP, "R6 random back-to-back",
                    st - prevSt, (nine ? 11 : 10) * bitP);
            prevSt = st;
          end
        end
      join
    end

    summary();
    $finish;
  end

endmodule